// File: doc/BRIEF.md
# Bus Cycle Sequencer with Backoff Restart

This block is the master-side cycle sequencer of a simple processor-style external bus. It walks a bus cycle through an address phase and a data phase. Each phase holds for a whole clock. A single transfer ends on the plain ready input. A burst ends when burst ready and the last-transfer flag arrive in the same cycle. While the bus is held, snooped or idle with no work, the sequencer parks in its idle state. When a cycle ends and the next request is already waiting, it chains straight into a fresh address phase.

A backoff input can abort the cycle in flight during its address or data phase. The sequencer then waits in a backoff state for as long as backoff stays high. After that it reissues the same cycle through a restart-address phase and goes on to the data phase. The cycle attributes (address, cycle kind and an "uncached single code fetch" flag) are captured when the address phase starts. They stay frozen until the cycle is over, so the restart drives the same cycle again.

There is one special case at restart. If the aborted cycle was an uncached, single-transfer code fetch, a hold request seen in the restart-address phase drops the fetch and sends the sequencer to idle. For any other cycle, hold is ignored on the backoff path.

The states are named idle, address, data, backoff-wait and restart-address. Their transitions are: launch (idle to address), issue (address to data), wait (data to data), chain (data to address), finish (data to idle), abort (address, data or restart-address to backoff-wait), linger (backoff-wait to itself), resume (backoff-wait to restart-address), reissue (restart-address to data) and drop (restart-address to idle).

Top module: `bus_cycle_seq`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in idle (state code 0). Address strobe is low and the captured attributes read as zero.
- R2: State codes on `bus_state` are idle=0, address=1, data=2, backoff-wait=3, restart-address=4. Idle launches into address only when request is high and hold, snoop hold and backoff are all low. Otherwise it stays idle.
- R3: The address phase lasts exactly one clock and is followed by data when backoff is low. `addr_strobe` is high in address and restart-address only, so it is never high in two consecutive clocks.
- R4: The data phase completes on `rdy` high, or on `brdy` and `last_xfer` both high. Burst ready without the last flag, or no ready at all, keeps the sequencer in data.
- R5: When data completes with request high and hold, snoop hold and backoff low, the next state is address.
- R6: When data completes with backoff low and any of hold, snoop hold or no request, the next state is idle.
- R7: Backoff high in address or data moves the sequencer to backoff-wait, and this takes priority over ready. Backoff-wait holds while backoff stays high.
- R8: Backoff low in backoff-wait moves to restart-address, which asserts the strobe. From restart-address, backoff high returns to backoff-wait.
- R9: In restart-address with backoff low, hold sends the sequencer to idle only when the captured uncached-code-fetch flag is 1. In every other case the next state is data, whatever hold is.
- R10: Address, kind and fetch flag are captured from the request inputs on entry to the address phase. They stay unchanged through data, backoff-wait and restart-address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_pend | input | 1 | A bus request is waiting |
| hold_req | input | 1 | Bus hold request from another master |
| snoop_hold | input | 1 | Address hold request for a snoop |
| backoff | input | 1 | Abort the current cycle and release the bus |
| rdy | input | 1 | Non-burst ready, ends the cycle |
| brdy | input | 1 | Burst ready for one beat |
| last_xfer | input | 1 | Marks the final beat of a cycle |
| req_addr | input | ADDR_W | Address of the waiting request |
| req_kind | input | KIND_W | Cycle kind of the waiting request |
| req_pf_nc | input | 1 | Waiting request is an uncached single-transfer code fetch |
| addr_strobe | output | 1 | Address strobe |
| bus_state | output | 3 | Current state code |
| cyc_addr | output | ADDR_W | Captured address of the current cycle |
| cyc_kind | output | KIND_W | Captured cycle kind |
| cyc_pf_nc | output | 1 | Captured uncached-code-fetch flag |

## Verification
The embedded properties check the rules of single transitions on every clock: the gate on leaving idle, the one-clock address phase and strobe, waiting in data without a completion, lingering in and resuming from backoff-wait, and frozen attributes in the non-launch states. Some behaviour only the bench's scenarios can show. The bench steers the sequencer into each of the five states, with both settings of the fetch flag, and applies every combination of the seven control inputs. It then compares the next state, the strobe and the captured attributes with an independent model. This sweep covers the choice between chaining and finishing, the priority of backoff over ready, and the hold case on the restart path, which is the only place where the captured fetch flag matters.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_DATA  = 3'd2,
        ST_BOFF  = 3'd3,
        ST_RADDR = 3'd4
    } bus_state_e;

    typedef struct packed {
        logic pend;
        logic hold;
        logic ahold;
        logic boff;
        logic rdy;
        logic brdy;
        logic last;
    } bus_ctl_s;

endpackage

// File: rtl/bcs_attr_latch.sv
module bcs_attr_latch #(
    parameter int WIDTH = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/bcs_fsm.sv
module bcs_fsm
    import bcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_ctl_s   ctl,
    input  logic       cyc_pf_nc,
    output bus_state_e state,
    output logic       load,
    output logic       strobe
);

    bus_state_e state_q;
    bus_state_e state_d;
    logic       xfer_done;
    logic       launch_ok;
    logic       chain_ok;
    logic       drop_ok;

    always_comb begin
        xfer_done = ctl.rdy | (ctl.brdy & ctl.last);
        chain_ok  = ctl.pend & ~ctl.hold & ~ctl.ahold;
        launch_ok = chain_ok & ~ctl.boff;
        drop_ok   = ctl.hold & cyc_pf_nc;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (launch_ok) state_d = ST_ADDR;
            end
            ST_ADDR: begin
                state_d = ctl.boff ? ST_BOFF : ST_DATA;
            end
            ST_DATA: begin
                if (ctl.boff) begin
                    state_d = ST_BOFF;
                end else if (xfer_done) begin
                    state_d = chain_ok ? ST_ADDR : ST_IDLE;
                end
            end
            ST_BOFF: begin
                if (!ctl.boff) state_d = ST_RADDR;
            end
            ST_RADDR: begin
                if (ctl.boff) begin
                    state_d = ST_BOFF;
                end else begin
                    state_d = drop_ok ? ST_IDLE : ST_DATA;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state  = state_q;
        strobe = (state_q == ST_ADDR) || (state_q == ST_RADDR);
        load   = (state_d == ST_ADDR);
    end

    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (state_q == ST_IDLE && !strobe));

    // R2
    a_r2_idle_gate: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !(ctl.pend && !ctl.hold && !ctl.ahold && !ctl.boff))
        |=> state_q == ST_IDLE);

    // R3
    a_r3_strobe_single: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

    a_r3_addr_to_data: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ADDR && !ctl.boff) |=> state_q == ST_DATA);

    // R4
    a_r4_data_wait: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA && !ctl.boff && !ctl.rdy && !(ctl.brdy && ctl.last))
        |=> state_q == ST_DATA);

    // R7
    a_r7_abort: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_ADDR || state_q == ST_DATA) && ctl.boff) |=> state_q == ST_BOFF);

    a_r7_linger: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BOFF && ctl.boff) |=> (state_q == ST_BOFF && !strobe));

    // R8
    a_r8_resume: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BOFF && !ctl.boff) |=> (state_q == ST_RADDR && strobe));

    // R9
    a_r9_reissue: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RADDR && !ctl.boff && !(ctl.hold && cyc_pf_nc))
        |=> state_q == ST_DATA);

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int KIND_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_pend,
    input  logic              hold_req,
    input  logic              snoop_hold,
    input  logic              backoff,
    input  logic              rdy,
    input  logic              brdy,
    input  logic              last_xfer,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [KIND_W-1:0] req_kind,
    input  logic              req_pf_nc,
    output logic              addr_strobe,
    output logic [2:0]        bus_state,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [KIND_W-1:0] cyc_kind,
    output logic              cyc_pf_nc
);

    localparam int ATTR_W = ADDR_W + KIND_W + 1;

    bus_ctl_s          ctl;
    bus_state_e        state;
    logic              load;
    logic [ATTR_W-1:0] attr_d;
    logic [ATTR_W-1:0] attr_q;

    always_comb begin
        ctl.pend  = req_pend;
        ctl.hold  = hold_req;
        ctl.ahold = snoop_hold;
        ctl.boff  = backoff;
        ctl.rdy   = rdy;
        ctl.brdy  = brdy;
        ctl.last  = last_xfer;
        attr_d    = {req_addr, req_kind, req_pf_nc};
    end

    bcs_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .cyc_pf_nc (attr_q[0]),
        .state     (state),
        .load      (load),
        .strobe    (addr_strobe)
    );

    bcs_attr_latch #(.WIDTH(ATTR_W)) u_attr (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .d    (attr_d),
        .q    (attr_q)
    );

    always_comb begin
        bus_state = state;
        cyc_addr  = attr_q[ATTR_W-1 -: ADDR_W];
        cyc_kind  = attr_q[KIND_W:1];
        cyc_pf_nc = attr_q[0];
    end

    // R10
    a_r10_attr_frozen: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA || state == ST_BOFF || state == ST_RADDR) |-> $stable(attr_q));

    // R10
    a_r10_attr_capture: assert property (@(posedge clk) disable iff (rst)
        load |=> (attr_q == $past(attr_d)));

endmodule

// File: tb/test_bus_cycle_seq.sv
module test_bus_cycle_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int KW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b0;
    logic          req_pend, hold_req, snoop_hold, backoff, rdy, brdy, last_xfer;
    logic [AW-1:0] req_addr;
    logic [KW-1:0] req_kind;
    logic          req_pf_nc;
    logic          addr_strobe;
    logic [2:0]    bus_state;
    logic [AW-1:0] cyc_addr;
    logic [KW-1:0] cyc_kind;
    logic          cyc_pf_nc;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    bus_cycle_seq #(.ADDR_W(AW), .KIND_W(KW)) i_bus_cycle_seq (
        .clk(clk), .rst(rst), .req_pend(req_pend), .hold_req(hold_req),
        .snoop_hold(snoop_hold), .backoff(backoff), .rdy(rdy), .brdy(brdy),
        .last_xfer(last_xfer), .req_addr(req_addr), .req_kind(req_kind),
        .req_pf_nc(req_pf_nc), .addr_strobe(addr_strobe), .bus_state(bus_state),
        .cyc_addr(cyc_addr), .cyc_kind(cyc_kind), .cyc_pf_nc(cyc_pf_nc)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic quiet();
        req_pend = 0; hold_req = 0; snoop_hold = 0; backoff = 0;
        rdy = 0; brdy = 0; last_xfer = 0;
    endtask

    // Independent next-state model: 0 idle, 1 address, 2 data, 3 backoff-wait, 4 restart
    function automatic int model(input int s, input logic [6:0] v, input bit pf, output string tag);
        bit rq, h, ah, bo, rd, br, ls, done;
        {rq, h, ah, bo, rd, br, ls} = v;
        done = rd | (br & ls);
        case (s)
            0: begin tag = "R2"; return (rq && !h && !ah && !bo) ? 1 : 0; end
            1: begin tag = bo ? "R7" : "R3"; return bo ? 3 : 2; end
            2: begin
                if (bo) begin tag = "R7"; return 3; end
                if (!done) begin tag = "R4"; return 2; end
                if (rq && !h && !ah) begin tag = "R5"; return 1; end
                tag = "R6"; return 0;
            end
            3: begin tag = bo ? "R7" : "R8"; return bo ? 3 : 4; end
            default: begin
                if (bo) begin tag = "R8"; return 3; end
                tag = "R9";
                return (h && pf) ? 0 : 2;
            end
        endcase
    endfunction

    initial begin
        quiet();
        req_addr = '0; req_kind = '0; req_pf_nc = 0;
        for (int s = 0; s < 5; s++) begin
            for (int pf = 0; pf < 2; pf++) begin
                for (int v = 0; v < 128; v++) begin
                    logic [AW+KW:0] held;
                    logic [AW+KW:0] fresh;
                    logic [AW+KW:0] exp_attr;
                    string tag;
                    int nxt;
                    // reset from wherever the last vector left it (R1)
                    @(negedge clk);
                    rst = 1; quiet();
                    @(negedge clk);
                    rst = 0;
                    chk(bus_state == 3'd0 && !addr_strobe, "R1 state/strobe",
                        {addr_strobe, bus_state}, 0);
                    chk({cyc_addr, cyc_kind, cyc_pf_nc} == 0, "R1 attributes",
                        {cyc_addr, cyc_kind, cyc_pf_nc}, 0);
                    held = '0;
                    if (s >= 1) begin
                        req_pend = 1; req_addr = 16'hBEEF; req_kind = 3'd5; req_pf_nc = pf[0];
                        @(negedge clk);
                        held = {16'hBEEF, 3'd5, pf[0]};
                        quiet();
                    end
                    if (s == 2) @(negedge clk);
                    if (s >= 3) begin
                        backoff = 1;
                        @(negedge clk);
                        if (s == 4) begin
                            backoff = 0;
                            @(negedge clk);
                        end
                    end
                    chk(bus_state == s[2:0], "R2 steer", bus_state, s);
                    // apply vector
                    {req_pend, hold_req, snoop_hold, backoff, rdy, brdy, last_xfer} = v[6:0];
                    req_addr = 16'h0100 + v[15:0];
                    req_kind = v[2:0];
                    req_pf_nc = ~pf[0];
                    fresh = {req_addr, req_kind, req_pf_nc};
                    nxt = model(s, v[6:0], held[0], tag);
                    @(negedge clk);
                    chk(bus_state == nxt[2:0], {tag, " next state"}, bus_state, nxt);
                    chk(addr_strobe == (nxt == 1 || nxt == 4), (nxt == 4) ? "R8 strobe" : "R3 strobe",
                        addr_strobe, (nxt == 1 || nxt == 4));
                    exp_attr = (nxt == 1) ? fresh : held;
                    chk({cyc_addr, cyc_kind, cyc_pf_nc} == exp_attr, "R10 attributes",
                        {cyc_addr, cyc_kind, cyc_pf_nc}, exp_attr);
                end
            end
        end
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog R1 actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule